// File: doc/BRIEF.md
# System Call Entry Unit

This block performs the state transfer that happens when a processor takes a system call. Two call flavours are supported: a classic call and a vectored call. When the start strobe is raised, the block does four things in the same clock edge. It computes the return address. It forms a saved image of the current machine state register, with fixed reserved sub-fields cleared. It loads an externally supplied new machine state value. It computes the address of the next instruction.

The classic call saves the return address and the image into the two interrupt save registers. It then jumps to a fixed handler address. The vectored call saves the return address into the link register and the image into the count register. It then jumps to a handler slot chosen by a 7-bit level field.

All results appear together, registered, one cycle after the start strobe. The write enables select which architectural registers the surrounding core should update. Instruction decode, privilege checks and the choice of the new machine state value are done elsewhere.

Top module: `sc_entry_unit`

## Requirements
- R1: While reset is held and in the cycle after reset is released with no start, `res_valid` and all write enables (`ret_to_save0_we`, `img_to_save1_we`, `ret_to_link_we`, `img_to_count_we`, `state_we`) are 0.
- R2: A start with `vec_sel`=0 (classic) makes `res_valid`, `ret_to_save0_we` and `img_to_save1_we` 1 and `ret_to_link_we`, `img_to_count_we` 0 in the following cycle.
- R3: `ret_addr` in the cycle after a start equals the `cur_pc` sampled at the start plus 4, taken modulo 2^64.
- R4: `img_val` after a start equals the sampled `cur_state` with state bits 33–36 and 42–47 cleared, numbering bit 0 as the most significant bit (LSB-0 positions 30:27 and 21:16); every other bit is copied unchanged.
- R5: The classic call sets `next_pc` to 0x0000_0000_0000_0C00.
- R6: A start with `vec_sel`=1 (vectored) makes `res_valid`, `ret_to_link_we` and `img_to_count_we` 1 and `ret_to_save0_we`, `img_to_save1_we` 0 in the following cycle.
- R7: The vectored call sets `next_pc` to 0x17000 + `level` × 0x20 for every 7-bit `level`.
- R8: Each accepted call asserts `state_we` and drives `state_val` with the `new_state` sampled at the start, while `img_val` holds the state from before that update.
- R9: A cycle without start is followed by a cycle in which `res_valid` and every write enable are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept a system call this cycle |
| vec_sel | input | 1 | 0 = classic call, 1 = vectored call |
| cur_pc | input | 64 | Address of the calling instruction |
| cur_state | input | 64 | Current machine state register |
| new_state | input | 64 | Machine state value to install |
| level | input | 7 | Level field selecting the vectored handler slot |
| res_valid | output | 1 | Results below are valid this cycle |
| ret_addr | output | 64 | Return address |
| ret_to_save0_we | output | 1 | Write `ret_addr` into save register 0 |
| ret_to_link_we | output | 1 | Write `ret_addr` into the link register |
| img_val | output | 64 | Masked saved-state image |
| img_to_save1_we | output | 1 | Write `img_val` into save register 1 |
| img_to_count_we | output | 1 | Write `img_val` into the count register |
| state_we | output | 1 | Write `state_val` into the machine state register |
| state_val | output | 64 | New machine state value |
| next_pc | output | 64 | Next instruction address |

## Verification
Classic calls are driven with return addresses that include the all-ones address, so the wrap of the +4 addition is exercised. Those calls also use state patterns such as all ones, alternating bits and single walking bits. All ones exposes every cleared position at once, and a walking bit shows that each single position is either copied or cleared as required. Vectored calls sweep all 128 level values, which separates a correct slot multiplier from a wrong shift or a truncated field. Alternating the two flavours back to back, with idle cycles in between, shows that the write enables follow the current call and not a previous one.

// File: rtl/sc_entry_pkg.sv
package sc_entry_pkg;

    localparam int XLEN      = 64;
    localparam int LEVEL_W   = 7;
    localparam int PC_STEP   = 4;
    localparam int SLOT_LOG2 = 5;

    localparam logic [XLEN-1:0] CLASSIC_TARGET = 64'h0000_0000_0000_0C00;
    localparam logic [XLEN-1:0] VECTOR_BASE    = 64'h0000_0000_0001_7000;

    typedef enum logic {
        CALL_CLASSIC = 1'b0,
        CALL_VECTOR  = 1'b1
    } call_kind_e;

    typedef struct packed {
        logic             valid;
        call_kind_e       kind;
        logic [XLEN-1:0]  ret_addr;
        logic [XLEN-1:0]  image;
        logic [XLEN-1:0]  state;
        logic [XLEN-1:0]  target;
    } call_result_t;

    // Keep-mask for the saved image; positions given with bit 0 as MSB.
    function automatic logic [XLEN-1:0] image_keep_mask();
        logic [XLEN-1:0] m;
        for (int i = 0; i < XLEN; i++) begin
            m[XLEN-1-i] = !(((i >= 33) && (i <= 36)) || ((i >= 42) && (i <= 47)));
        end
        return m;
    endfunction

endpackage

// File: rtl/sc_image_mask.sv
module sc_image_mask
    import sc_entry_pkg::*;
(
    input  logic [XLEN-1:0] state_in,
    output logic [XLEN-1:0] image_out
);
    localparam logic [XLEN-1:0] KEEP = image_keep_mask();

    always_comb begin
        image_out = state_in & KEEP;
    end
endmodule

// File: rtl/sc_target_gen.sv
module sc_target_gen
    import sc_entry_pkg::*;
#(
    parameter int LVL_W = LEVEL_W
) (
    input  call_kind_e        kind,
    input  logic [LVL_W-1:0]  lvl,
    output logic [XLEN-1:0]   target
);
    localparam int PAD_W = XLEN - LVL_W - SLOT_LOG2;

    logic [XLEN-1:0] slot_off;

    always_comb begin
        slot_off = {{PAD_W{1'b0}}, lvl, {SLOT_LOG2{1'b0}}};
        unique case (kind)
            CALL_CLASSIC: target = CLASSIC_TARGET;
            CALL_VECTOR:  target = VECTOR_BASE + slot_off;
            default:      target = CLASSIC_TARGET;
        endcase
    end
endmodule

// File: rtl/sc_result_reg.sv
module sc_result_reg
    import sc_entry_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  call_result_t  d,
    output call_result_t  q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
            if (!d.valid) begin
                q.kind <= CALL_CLASSIC;
            end
        end
    end
endmodule

// File: rtl/sc_entry_unit.sv
module sc_entry_unit
    import sc_entry_pkg::*;
#(
    parameter int LVL_W = LEVEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              vec_sel,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   cur_state,
    input  logic [XLEN-1:0]   new_state,
    input  logic [LVL_W-1:0]  level,
    output logic              res_valid,
    output logic [XLEN-1:0]   ret_addr,
    output logic              ret_to_save0_we,
    output logic              ret_to_link_we,
    output logic [XLEN-1:0]   img_val,
    output logic              img_to_save1_we,
    output logic              img_to_count_we,
    output logic              state_we,
    output logic [XLEN-1:0]   state_val,
    output logic [XLEN-1:0]   next_pc
);
    localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

    call_kind_e       kind_d;
    logic [XLEN-1:0]  image_d;
    logic [XLEN-1:0]  target_d;
    call_result_t     res_d;
    call_result_t     res_q;

    assign kind_d = vec_sel ? CALL_VECTOR : CALL_CLASSIC;

    sc_image_mask u_mask (
        .state_in  (cur_state),
        .image_out (image_d)
    );

    sc_target_gen #(.LVL_W(LVL_W)) u_target (
        .kind   (kind_d),
        .lvl    (level),
        .target (target_d)
    );

    always_comb begin
        res_d          = '0;
        res_d.valid    = start;
        res_d.kind     = kind_d;
        res_d.ret_addr = cur_pc + STEP;
        res_d.image    = image_d;
        res_d.state    = new_state;
        res_d.target   = target_d;
    end

    sc_result_reg u_reg (
        .clk (clk),
        .rst (rst),
        .d   (res_d),
        .q   (res_q)
    );

    assign res_valid       = res_q.valid;
    assign ret_addr        = res_q.ret_addr;
    assign img_val         = res_q.image;
    assign state_val       = res_q.state;
    assign next_pc         = res_q.target;
    assign state_we        = res_q.valid;
    assign ret_to_save0_we = res_q.valid && (res_q.kind == CALL_CLASSIC);
    assign img_to_save1_we = res_q.valid && (res_q.kind == CALL_CLASSIC);
    assign ret_to_link_we  = res_q.valid && (res_q.kind == CALL_VECTOR);
    assign img_to_count_we = res_q.valid && (res_q.kind == CALL_VECTOR);

    // R2
    classic_we_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !vec_sel) |=> (ret_to_save0_we && img_to_save1_we && !ret_to_link_we && !img_to_count_we));

    // R6
    vector_we_chk: assert property (@(posedge clk) disable iff (rst)
        (start && vec_sel) |=> (ret_to_link_we && img_to_count_we && !ret_to_save0_we && !img_to_save1_we));

    // R3
    ret_addr_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (ret_addr == $past(cur_pc) + STEP));

    // R4
    image_fields_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> ((img_val[30:27] == 4'b0) && (img_val[21:16] == 6'b0) && (img_val[63:31] == $past(cur_state[63:31]))));

    // R5
    classic_target_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !vec_sel) |=> (next_pc == CLASSIC_TARGET));

    // R8
    new_state_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (state_we && state_val == $past(new_state)));

    // R9
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> (!res_valid && !state_we && !ret_to_save0_we && !ret_to_link_we));
endmodule

// File: tb/sc_entry_unit_tb_top.sv
module sc_entry_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        vec_sel;
    logic [63:0] cur_pc;
    logic [63:0] cur_state;
    logic [63:0] new_state;
    logic [6:0]  level;
    logic        res_valid;
    logic [63:0] ret_addr;
    logic        ret_to_save0_we;
    logic        ret_to_link_we;
    logic [63:0] img_val;
    logic        img_to_save1_we;
    logic        img_to_count_we;
    logic        state_we;
    logic [63:0] state_val;
    logic [63:0] next_pc;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_entry_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .vec_sel(vec_sel),
        .cur_pc(cur_pc), .cur_state(cur_state), .new_state(new_state), .level(level),
        .res_valid(res_valid), .ret_addr(ret_addr),
        .ret_to_save0_we(ret_to_save0_we), .ret_to_link_we(ret_to_link_we),
        .img_val(img_val), .img_to_save1_we(img_to_save1_we), .img_to_count_we(img_to_count_we),
        .state_we(state_we), .state_val(state_val), .next_pc(next_pc)
    );

    function automatic logic [63:0] exp_image(input logic [63:0] s);
        logic [63:0] r = s;
        for (int b = 33; b <= 36; b++) r[63-b] = 1'b0;
        for (int b = 42; b <= 47; b++) r[63-b] = 1'b0;
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] we_vec();
        return {res_valid, ret_to_save0_we, img_to_save1_we, ret_to_link_we, img_to_count_we};
    endfunction

    // Drive one call at negedge, sample results at the following negedge.
    task automatic do_call(input bit vec, input logic [63:0] pc, input logic [63:0] st,
                           input logic [63:0] ns, input logic [6:0] lv);
        start = 1'b1; vec_sel = vec; cur_pc = pc; cur_state = st; new_state = ns; level = lv;
        @(negedge clk);
        start = 1'b0; cur_state = ~st; new_state = ~ns;
        if (vec) begin
            check("R6", {59'd0, we_vec()}, {59'd0, 5'b10011});
            check("R7", next_pc, 64'h17000 + 64'(lv) * 64'h20);
        end else begin
            check("R2", {59'd0, we_vec()}, {59'd0, 5'b11100});
            check("R5", next_pc, 64'hC00);
        end
        check("R3", ret_addr, pc + 64'd4);
        check("R4", img_val, exp_image(st));
        check("R8", {63'd0, state_we}, 64'd1);
        check("R8", state_val, ns);
    endtask

    task automatic idle_check();
        @(negedge clk);
        check("R9", {58'd0, we_vec(), state_we}, 64'd0);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; vec_sel = 1'b0;
        cur_pc = '0; cur_state = '0; new_state = '0; level = '0;
        repeat (3) @(negedge clk);
        check("R1", {58'd0, we_vec(), state_we}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {58'd0, we_vec(), state_we}, 64'd0);

        do_call(1'b0, 64'h0000_0000_0000_1000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 7'd0);
        do_call(1'b0, 64'hFFFF_FFFF_FFFF_FFFC, 64'hAAAA_AAAA_AAAA_AAAA, 64'h1234_5678_9ABC_DEF0, 7'd3);
        do_call(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_5555_5555_5555, 64'h0, 7'd127);
        idle_check();
        for (int b = 0; b < 64; b++) begin
            do_call(1'b0, 64'(b) << 3, 64'd1 << b, 64'(b), 7'(b));
        end
        idle_check();
        for (int lv = 0; lv < 128; lv++) begin
            do_call(1'b1, 64'h7FFF_0000_0000_0000 + 64'(lv), {32'hDEAD_BEEF, 25'd0, 7'(lv)},
                    ~64'(lv), 7'(lv));
            if (lv % 16 == 15) idle_check();
        end
        for (int k = 0; k < 8; k++) begin
            do_call(k[0], 64'hFFFF_FFFF_FFFF_FFF8 + 64'(k), 64'hFFFF_FFFF_FFFF_FFFF, 64'(k), 7'(k * 17));
        end
        idle_check();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule